// File: doc/BRIEF.md
# Processor Status Flag Register

This block holds the eight-bit condition and control byte of a small processor core together with the logic that updates it. Each cycle it can take the flags produced by the arithmetic/logic unit and merge them into the byte, one flag at a time, under a write mask. The sign flag is not taken from the ALU. It is always formed inside the block from the merged negative and overflow flags.

The top bit is the global interrupt enable. Two dedicated strobes set and clear it. The block drives it to the interrupt controller, and it gates the per-source enables so that no source appears enabled while the bit is low. Accepting an interrupt does not touch the bit. A transfer bit supports bit-store and bit-load operations. Bit-store copies a selected bit of a register operand into the transfer bit. Bit-load returns the operand with the selected bit replaced by the transfer bit.

The whole byte can also be read and written as a memory-mapped I/O location. A write that changes the interrupt enable stretches its access with a one-cycle wait. The wait is sequenced by a two-state machine. In `ST_RUN` the block is ready; a write that flips bit 7 moves it to `ST_STALL`. `ST_STALL` drives `io_wait` high and returns to `ST_RUN` unconditionally on the next edge.

Top module: `status_flag_unit`

## Requirements
- R1: `io_rdata` shows the register with bit 7 = interrupt enable, 6 = transfer, 5 = half carry, 4 = sign, 3 = overflow, 2 = negative, 1 = zero, 0 = carry, and `gie` equals bit 7.
- R2: Asserting `rst_n` low clears all eight bits, `io_wait` and `irq_active`.
- R3: When `alu_mask[5]` is set in an ALU update, the new sign bit equals the merged negative bit XOR the merged overflow bit.
- R4: `irq_active` equals `irq_en` when `gie` is 1, and is all zeros when `gie` is 0.
- R5: `irq_ack` has no effect on the interrupt enable bit.
- R6: An I/O write whose bit 7 differs from the current bit 7 drives `io_wait` high for exactly the one cycle after the write edge.
- R7: `bst_en` loads `opnd[bit_sel]` into bit 6. While `bld_en` is high, `bld_out` is `opnd` with bit `bit_sel` replaced by bit 6; otherwise `bld_out` is `opnd`.
- R8: `int_set` sets bit 7, and `int_clr` clears it. If both are asserted, clear wins. Neither changes bits 6..0.
- R9: With `alu_upd` high, `alu_flags`/`alu_mask` index 0 = carry, 1 = zero, 2 = negative, 3 = overflow, 4 = half carry. A flag is written only when its mask bit is 1; all other flags keep their values.
- R10: An I/O write loads all of `io_wdata` unchanged and overrides every other update in the same cycle.
- R11: An I/O write that keeps bit 7 unchanged does not raise `io_wait`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alu_upd | input | 1 | Apply ALU flag results this cycle |
| alu_mask | input | 6 | Per-flag write mask; bit 5 enables sign derivation |
| alu_flags | input | 5 | ALU results {half carry, overflow, negative, zero, carry} |
| int_set | input | 1 | Set interrupt enable |
| int_clr | input | 1 | Clear interrupt enable |
| irq_ack | input | 1 | An interrupt is being taken |
| irq_en | input | NIRQ | Per-source interrupt enables |
| irq_active | output | NIRQ | Source enables gated by the global enable |
| gie | output | 1 | Global interrupt enable |
| bst_en | input | 1 | Bit-store: copy operand bit to transfer bit |
| bld_en | input | 1 | Bit-load: insert transfer bit into operand |
| bit_sel | input | 3 | Operand bit select for store and load |
| opnd | input | 8 | Register operand |
| bld_out | output | 8 | Operand after bit-load |
| io_wr | input | 1 | I/O write strobe |
| io_wdata | input | 8 | I/O write data |
| io_rdata | output | 8 | I/O read data (current register) |
| io_wait | output | 1 | Wait state for the current I/O access |

## Verification
The wait-state checks assume the bus master honours `io_wait` and issues no second I/O write in the cycle the wait is high. The bench always idles for at least one cycle after any write that flips bit 7. The sign and set/clear properties assume no I/O write in the same cycle, because a write overrides them. The bench applies each update path on its own, then issues one deliberate collision cycle to exercise the priority rule.

// File: rtl/sfu_pkg.sv
`timescale 1ns/1ps
package sfu_pkg;
    localparam int SR_W   = 8;
    localparam int SEL_W  = $clog2(SR_W);
    localparam int ALU_W  = 5;
    localparam int MSK_W  = ALU_W + 1;

    // bit positions in the status byte
    localparam int B_C = 0;
    localparam int B_Z = 1;
    localparam int B_N = 2;
    localparam int B_V = 3;
    localparam int B_S = 4;
    localparam int B_H = 5;
    localparam int B_T = 6;
    localparam int B_I = 7;

    // index into alu_flags / alu_mask
    localparam int F_C = 0;
    localparam int F_Z = 1;
    localparam int F_N = 2;
    localparam int F_V = 3;
    localparam int F_H = 4;
    localparam int M_S = 5;

    typedef enum logic [0:0] {
        ST_RUN   = 1'b0,
        ST_STALL = 1'b1
    } wait_st_e;
endpackage

// File: rtl/sfu_alu_merge.sv
`timescale 1ns/1ps
module sfu_alu_merge
    import sfu_pkg::*;
(
    input  logic [SR_W-1:0]  cur,
    input  logic [MSK_W-1:0] mask,
    input  logic [ALU_W-1:0] flags,
    output logic [SR_W-1:0]  nxt
);
    localparam int MAP [ALU_W] = '{B_C, B_Z, B_N, B_V, B_H};

    always_comb begin
        nxt = cur;
        for (int k = 0; k < ALU_W; k++) begin
            if (mask[k]) nxt[MAP[k]] = flags[k];
        end
        if (mask[M_S]) nxt[B_S] = nxt[B_N] ^ nxt[B_V];
    end
endmodule

// File: rtl/sfu_bit_xfer.sv
`timescale 1ns/1ps
module sfu_bit_xfer
    import sfu_pkg::*;
(
    input  logic [SR_W-1:0]  opnd,
    input  logic [SEL_W-1:0] bit_sel,
    input  logic             t_cur,
    input  logic             bld_en,
    output logic             t_pick,
    output logic [SR_W-1:0]  bld_out
);
    always_comb begin
        t_pick  = opnd[bit_sel];
        bld_out = opnd;
        if (bld_en) bld_out[bit_sel] = t_cur;
    end
endmodule

// File: rtl/sfu_wait_fsm.sv
`timescale 1ns/1ps
module sfu_wait_fsm
    import sfu_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wait_req,
    output logic io_wait
);
    wait_st_e st_q, st_d;

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_RUN;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d    = st_q;
        io_wait = 1'b0;
        unique case (st_q)
            ST_RUN: begin
                if (wait_req) st_d = ST_STALL;
            end
            ST_STALL: begin
                io_wait = 1'b1;
                st_d    = ST_RUN;
            end
            default: st_d = ST_RUN;
        endcase
    end

    AST_WAIT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        io_wait |=> !io_wait); // R6
    AST_WAIT_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_RUN && wait_req) |=> io_wait); // R6
endmodule

// File: rtl/status_flag_unit.sv
`timescale 1ns/1ps
module status_flag_unit
    import sfu_pkg::*;
#(
    parameter int NIRQ = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alu_upd,
    input  logic [5:0]       alu_mask,
    input  logic [4:0]       alu_flags,
    input  logic             int_set,
    input  logic             int_clr,
    input  logic             irq_ack,
    input  logic [NIRQ-1:0]  irq_en,
    output logic [NIRQ-1:0]  irq_active,
    output logic             gie,
    input  logic             bst_en,
    input  logic             bld_en,
    input  logic [2:0]       bit_sel,
    input  logic [7:0]       opnd,
    output logic [7:0]       bld_out,
    input  logic             io_wr,
    input  logic [7:0]       io_wdata,
    output logic [7:0]       io_rdata,
    output logic             io_wait
);
    logic [SR_W-1:0] sreg_q, sreg_d, merged;
    logic            t_pick, wait_req;

    sfu_alu_merge u_merge (
        .cur   (sreg_q),
        .mask  (alu_mask),
        .flags (alu_flags),
        .nxt   (merged)
    );

    sfu_bit_xfer u_xfer (
        .opnd    (opnd),
        .bit_sel (bit_sel),
        .t_cur   (sreg_q[B_T]),
        .bld_en  (bld_en),
        .t_pick  (t_pick),
        .bld_out (bld_out)
    );

    assign wait_req = io_wr && (io_wdata[B_I] != sreg_q[B_I]);

    sfu_wait_fsm u_wait (
        .clk      (clk),
        .rst_n    (rst_n),
        .wait_req (wait_req),
        .io_wait  (io_wait)
    );

    // lowest to highest priority; irq_ack deliberately leaves the enable alone
    always_comb begin
        sreg_d = sreg_q;
        if (alu_upd) sreg_d = merged;
        if (bst_en)  sreg_d[B_T] = t_pick;
        if (int_set) sreg_d[B_I] = 1'b1;
        if (int_clr) sreg_d[B_I] = 1'b0;
        if (io_wr)   sreg_d = io_wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sreg_q <= '0;
        else        sreg_q <= sreg_d;
    end

    assign io_rdata   = sreg_q;
    assign gie        = sreg_q[B_I];
    assign irq_active = irq_en & {NIRQ{sreg_q[B_I]}};

    AST_SIGN_XOR: assert property (@(posedge clk) disable iff (!rst_n)
        (alu_upd && alu_mask[M_S] && !io_wr) |=> (io_rdata[B_S] == (io_rdata[B_N] ^ io_rdata[B_V]))); // R3
    AST_GIE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        !gie |-> (irq_active == '0)); // R4
    AST_ACK_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack && !io_wr && !int_set && !int_clr) |=> (gie == $past(gie))); // R5
    AST_TBIT_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        (bst_en && !io_wr) |=> (io_rdata[B_T] == $past(opnd[bit_sel]))); // R7
    AST_INT_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        ((int_set || int_clr) && !io_wr && !alu_upd && !bst_en) |=> (io_rdata[6:0] == $past(io_rdata[6:0]))); // R8
    AST_IO_PRIO: assert property (@(posedge clk) disable iff (!rst_n)
        io_wr |=> (io_rdata == $past(io_wdata))); // R10
    AST_NO_WAIT_SAME: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && !io_wait && (io_wdata[B_I] == gie)) |=> !io_wait); // R11
endmodule

// File: tb/status_flag_unit_bench.sv
`timescale 1ns/1ps
module status_flag_unit_bench;
    localparam int NIRQ = 4;
    localparam int NVEC = 8;
    // {mask[5:0], flags[4:0], expected io_rdata[7:0]}
    localparam logic [18:0] VEC [NVEC] = '{
        {6'h3F, 5'h1F, 8'h2F},
        {6'h24, 5'h00, 8'h3B},
        {6'h01, 5'h00, 8'h3A},
        {6'h00, 5'h1F, 8'h3A},
        {6'h2C, 5'h04, 8'h36},
        {6'h10, 5'h00, 8'h16},
        {6'h0A, 5'h08, 8'h1C},
        {6'h20, 5'h00, 8'h0C}
    };

    logic clk = 1'b0;
    logic rst_n;
    logic alu_upd, int_set, int_clr, irq_ack, bst_en, bld_en, io_wr;
    logic [5:0] alu_mask;
    logic [4:0] alu_flags;
    logic [NIRQ-1:0] irq_en, irq_active;
    logic gie, io_wait;
    logic [2:0] bit_sel;
    logic [7:0] opnd, bld_out, io_wdata, io_rdata;

    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    status_flag_unit #(.NIRQ(NIRQ)) u_status_flag_unit (
        .clk(clk), .rst_n(rst_n), .alu_upd(alu_upd), .alu_mask(alu_mask),
        .alu_flags(alu_flags), .int_set(int_set), .int_clr(int_clr),
        .irq_ack(irq_ack), .irq_en(irq_en), .irq_active(irq_active), .gie(gie),
        .bst_en(bst_en), .bld_en(bld_en), .bit_sel(bit_sel), .opnd(opnd),
        .bld_out(bld_out), .io_wr(io_wr), .io_wdata(io_wdata),
        .io_rdata(io_rdata), .io_wait(io_wait)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #4000000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; alu_upd = 0; int_set = 0; int_clr = 0; irq_ack = 0;
        bst_en = 0; bld_en = 0; io_wr = 0; alu_mask = '0; alu_flags = '0;
        irq_en = '0; bit_sel = '0; opnd = '0; io_wdata = '0;
        @(negedge clk);
        step();
        chk("R2 reset byte", io_rdata, 8'h00);
        chk("R2 reset wait", io_wait, 0);
        chk("R2 reset gie", gie, 0);
        rst_n = 1'b1;
        step();

        io_wr = 1; io_wdata = 8'h00; step(); io_wr = 0;
        chk("R11 write keeps bit7", io_wait, 0);

        for (int i = 0; i < NVEC; i++) begin
            alu_upd = 1; alu_mask = VEC[i][18:13]; alu_flags = VEC[i][12:8];
            step();
            alu_upd = 0;
            chk("R9 R3 masked update", io_rdata, VEC[i][7:0]);
        end

        int_set = 1; step(); int_set = 0;
        chk("R8 set only bit7", io_rdata, 8'h8C);
        chk("R1 gie pin", gie, 1);
        irq_en = 4'b1010; #1;
        chk("R4 gated enables on", irq_active, 4'b1010);
        irq_ack = 1; step(); irq_ack = 0;
        chk("R5 ack keeps gie", gie, 1);
        int_clr = 1; step(); int_clr = 0;
        chk("R8 clear only bit7", io_rdata, 8'h0C);
        chk("R4 gated enables off", irq_active, 4'b0000);
        int_set = 1; step();
        int_clr = 1; step(); int_set = 0; int_clr = 0;
        chk("R8 clear wins", gie, 0);

        bst_en = 1; opnd = 8'h20; bit_sel = 3'd5; step(); bst_en = 0;
        chk("R7 store sets T", io_rdata, 8'h4C);
        bld_en = 1; opnd = 8'h00; bit_sel = 3'd3; #1;
        chk("R7 load T=1", bld_out, 8'h08);
        bld_en = 0;
        bst_en = 1; opnd = 8'h20; bit_sel = 3'd0; step(); bst_en = 0;
        chk("R7 store clears T", io_rdata, 8'h0C);
        bld_en = 1; opnd = 8'hFF; bit_sel = 3'd7; #1;
        chk("R7 load T=0", bld_out, 8'h7F);
        bld_en = 0; opnd = 8'h55; #1;
        chk("R7 load idle passthrough", bld_out, 8'h55);

        io_wr = 1; io_wdata = 8'hA5; step(); io_wr = 0;
        chk("R1 io readback", io_rdata, 8'hA5);
        chk("R6 wait raised", io_wait, 1);
        step();
        chk("R6 wait one cycle", io_wait, 0);
        io_wr = 1; io_wdata = 8'hA4; step(); io_wr = 0;
        chk("R11 no wait", io_wait, 0);
        chk("R1 io readback 2", io_rdata, 8'hA4);

        io_wr = 1; io_wdata = 8'h25; alu_upd = 1; alu_mask = 6'h3F; alu_flags = 5'h1F;
        int_set = 1; bst_en = 1; opnd = 8'hFF; bit_sel = 3'd0;
        step();
        io_wr = 0; alu_upd = 0; int_set = 0; bst_en = 0;
        chk("R10 io priority", io_rdata, 8'h25);
        chk("R6 wait on clear", io_wait, 1);
        step();

        int_set = 1; step(); int_set = 0;
        rst_n = 0; step();
        chk("R2 reset mid-run", io_rdata, 8'h00);
        chk("R2 reset irq gate", irq_active, 4'b0000);
        rst_n = 1; step();

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule